// File: doc/BRIEF.md
# Fixed-Step Digital Voltage Trim Loop

This block holds the DC level of a power supply output at a stored setpoint. An external analog path filters the supply output and compares it with the reference level that this block presents as `targetCode`. The block receives only the comparator's one-bit verdict: the measured output is either above or below the target. On each update it moves a trim code one step in the direction that corrects the error. The trim code drives the converter's trim node through an external DAC or PWM stage. The loop has no proportional gain. Every correction is the same single code step, so the supply settles into a small, bounded limit cycle around the target. The loop runs far slower than the converter's own regulation loop.

Three 10-bit setpoints sit in a small register bank: nominal, margin-high and margin-low. A margin-select input picks which one the channel regulates to, so a board can be margined up or down under test. Updates are paced by a programmable prescaler that is gated by an external tick enable. A fourth register holds the prescaler divisor. Setpoint writes are clamped to a lower floor that stands for the lowest regulable voltage.

Top module: `trim_loop`

## Requirements
- R1: After reset, `trimCode` is mid-scale (512 for a 10-bit code) and `targetCode` equals the nominal reset setpoint (600). The reset setpoints are high 660 and low 540, and the reset prescaler divisor is 3.
- R2: Each update changes `trimCode` by exactly one code. Between updates, the trim code never moves by more than one code per cycle.
- R3: When the synchronized comparator reads 1 (output above target), an update decrements `trimCode`. When it reads 0, an update increments it.
- R4: `trimCode` saturates at 0 and at 1023 and never wraps around.
- R5: While `tickEn` is held low, no update occurs. `trimCode` and `targetCode` stay unchanged.
- R6: With `tickEn` held high and divisor D, updates occur every D+1 clock cycles. The divisor is written at register address 3.
- R7: Register addresses 0, 1 and 2 hold the nominal, high and low setpoints. `marginSel` 0 selects nominal, 1 selects high, 2 selects low, and 3 selects nominal.
- R8: `targetCode` takes the newly selected or newly written setpoint only at the next update, never between updates.
- R9: A setpoint write below 96 is stored as 96. A write at or above 96 is stored unchanged.
- R10: `compAbove` passes through a two-flop synchronizer. In a closed loop with divisor 3 against a fixed threshold T, the trim code settles into a limit cycle confined to the two codes T and T+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| compAbove | input | 1 | Asynchronous comparator result, 1 when the measured output is above the target |
| tickEn | input | 1 | Enable for the update prescaler |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register address: 0 nominal, 1 high, 2 low, 3 divisor |
| wrData | input | 10 | Register write data |
| marginSel | input | 2 | Setpoint select: 0 nominal, 1 high, 2 low, 3 nominal |
| trimCode | output | 10 | Trim code toward the converter's trim node |
| targetCode | output | 10 | Active setpoint presented to the reference path |

## Verification
The assertions guard properties that must hold on every cycle:
- the unit-size step and the absence of wrap-around at either rail;
- the freeze of both trim code and target between update strobes;
- a strobe shape that always carries exactly one direction;
- the absence of updates without a tick enable;
- the setpoint floor.

The bench scenarios cover what a single cycle cannot show. A sweep of the prescaler divisor measures update spacing. Setpoint writes are swept across the floor boundary. The select decode and its tick-aligned switch-over are exercised. A closed loop against a fixed threshold confirms that the limit cycle stays confined to two codes.

// File: rtl/trim_pkg.sv
package trim_pkg;

  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_NOM  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_HIGH = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_LOW  = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_DIV  = 2'd3;

  typedef enum logic [1:0] {
    SEL_NOM  = 2'd0,
    SEL_HIGH = 2'd1,
    SEL_LOW  = 2'd2,
    SEL_ALT  = 2'd3
  } marginSel_t;

  // Strobes from the control side into the datapath, one cycle wide.
  typedef struct packed {
    logic load;  // update: latch selected setpoint, apply one step
    logic up;    // step trim code up
    logic down;  // step trim code down
  } trimStrobe_t;

endpackage

// File: rtl/trim_ctrl.sv
module trim_ctrl
  import trim_pkg::*;
#(
  parameter int SET_W   = 10,
  parameter int DIV_RST = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              compAbove,
  input  logic              tickEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [SET_W-1:0]  wrData,
  output trimStrobe_t       strobe
);

  localparam logic [SET_W-1:0] DIV_RST_C = SET_W'(DIV_RST);
  localparam logic [SET_W-1:0] CNT_ONE   = SET_W'(1);

  logic             compS1;
  logic             compS2;
  logic [SET_W-1:0] divReg;
  logic [SET_W-1:0] tickCnt;
  logic             wrap;

  // two-flop synchronizer for the comparator verdict
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      compS1 <= 1'b0;
      compS2 <= 1'b0;
    end else begin
      compS1 <= compAbove;
      compS2 <= compS1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divReg <= DIV_RST_C;
    end else if (wrEn && (wrAddr == ADDR_DIV)) begin
      divReg <= wrData;
    end
  end

  assign wrap = tickEn && (tickCnt >= divReg);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt <= '0;
    end else if (tickEn) begin
      tickCnt <= wrap ? '0 : (tickCnt + CNT_ONE);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strobe <= '0;
    end else begin
      strobe.load <= wrap;
      strobe.up   <= wrap && !compS2;
      strobe.down <= wrap && compS2;
    end
  end

  AST_STB_ONE_DIR: assert property (@(posedge clk) disable iff (!rstN) strobe.load |-> ($countones({strobe.up, strobe.down}) == 1)) else $error("strobe carries no single direction"); // R3
  AST_STB_IDLE: assert property (@(posedge clk) disable iff (!rstN) !strobe.load |-> $onehot0({strobe.up, strobe.down}) && !(strobe.up || strobe.down)) else $error("direction without update"); // R3
  AST_TICK_GATED: assert property (@(posedge clk) disable iff (!rstN) !$past(tickEn) |-> !strobe.load) else $error("update without tick enable"); // R5

endmodule

// File: rtl/trim_datapath.sv
module trim_datapath
  import trim_pkg::*;
#(
  parameter int SET_W      = 10,
  parameter int TRIM_W     = 10,
  parameter int CODE_FLOOR = 96,
  parameter int NOM_RST    = 600,
  parameter int HIGH_RST   = 660,
  parameter int LOW_RST    = 540
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [SET_W-1:0]  wrData,
  input  logic [1:0]        marginSel,
  input  trimStrobe_t       strobe,
  output logic [TRIM_W-1:0] trimCode,
  output logic [SET_W-1:0]  targetCode
);

  localparam int               BANK_N    = 3;
  localparam logic [SET_W-1:0] FLOOR_C   = SET_W'(CODE_FLOOR);
  localparam logic [TRIM_W-1:0] TRIM_MAX = '1;
  localparam logic [TRIM_W-1:0] TRIM_MID = TRIM_W'(1) << (TRIM_W - 1);
  localparam logic [TRIM_W-1:0] TRIM_ONE = TRIM_W'(1);
  localparam logic [TRIM_W:0]   STEP_X   = (TRIM_W + 1)'(1);

  logic [SET_W-1:0] clampedData;
  logic [SET_W-1:0] bankQ [BANK_N];
  logic [SET_W-1:0] selSet;

  assign clampedData = (wrData < FLOOR_C) ? FLOOR_C : wrData;

  for (genvar g = 0; g < BANK_N; g++) begin : gBank
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(g);
    localparam logic [SET_W-1:0]  RST_V   = (g == 0) ? SET_W'(NOM_RST) :
                                            (g == 1) ? SET_W'(HIGH_RST) : SET_W'(LOW_RST);
    logic [SET_W-1:0] regQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        regQ <= RST_V;
      end else if (wrEn && (wrAddr == MY_ADDR)) begin
        regQ <= clampedData;
      end
    end
    assign bankQ[g] = regQ;
  end

  always_comb begin
    case (marginSel_t'(marginSel))
      SEL_HIGH: selSet = bankQ[1];
      SEL_LOW:  selSet = bankQ[2];
      default:  selSet = bankQ[0];
    endcase
  end

  // active target switches only on an update strobe
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      targetCode <= SET_W'(NOM_RST);
    end else if (strobe.load) begin
      targetCode <= selSet;
    end
  end

  // fixed single-code step, saturating at both rails
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trimCode <= TRIM_MID;
    end else if (strobe.up && (trimCode != TRIM_MAX)) begin
      trimCode <= trimCode + TRIM_ONE;
    end else if (strobe.down && (trimCode != '0)) begin
      trimCode <= trimCode - TRIM_ONE;
    end
  end

  AST_UNIT_STEP: assert property (@(posedge clk) disable iff (!rstN) (trimCode != $past(trimCode)) |-> (({1'b0, trimCode} == ({1'b0, $past(trimCode)} + STEP_X)) || (({1'b0, trimCode} + STEP_X) == {1'b0, $past(trimCode)}))) else $error("trim moved by more than one code"); // R2
  AST_NO_WRAP_TOP: assert property (@(posedge clk) disable iff (!rstN) (($past(trimCode) == TRIM_MAX) && $past(strobe.up)) |-> (trimCode == TRIM_MAX)) else $error("trim wrapped at top"); // R4
  AST_NO_WRAP_BOT: assert property (@(posedge clk) disable iff (!rstN) (($past(trimCode) == '0) && $past(strobe.down)) |-> (trimCode == '0)) else $error("trim wrapped at bottom"); // R4
  AST_TRIM_HOLD: assert property (@(posedge clk) disable iff (!rstN) !$past(strobe.load) |-> $stable(trimCode)) else $error("trim moved between updates"); // R5
  AST_TARGET_HOLD: assert property (@(posedge clk) disable iff (!rstN) !$past(strobe.load) |-> $stable(targetCode)) else $error("target moved between updates"); // R8
  AST_FLOOR: assert property (@(posedge clk) disable iff (!rstN) targetCode >= FLOOR_C) else $error("target below floor"); // R9

endmodule

// File: rtl/trim_loop.sv
module trim_loop
  import trim_pkg::*;
#(
  parameter int SET_W      = 10,
  parameter int TRIM_W     = 10,
  parameter int CODE_FLOOR = 96,
  parameter int NOM_RST    = 600,
  parameter int HIGH_RST   = 660,
  parameter int LOW_RST    = 540,
  parameter int DIV_RST    = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              compAbove,
  input  logic              tickEn,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [SET_W-1:0]  wrData,
  input  logic [1:0]        marginSel,
  output logic [TRIM_W-1:0] trimCode,
  output logic [SET_W-1:0]  targetCode
);

  trimStrobe_t strobe;

  trim_ctrl #(
    .SET_W   (SET_W),
    .DIV_RST (DIV_RST)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .compAbove (compAbove),
    .tickEn    (tickEn),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .strobe    (strobe)
  );

  trim_datapath #(
    .SET_W      (SET_W),
    .TRIM_W     (TRIM_W),
    .CODE_FLOOR (CODE_FLOOR),
    .NOM_RST    (NOM_RST),
    .HIGH_RST   (HIGH_RST),
    .LOW_RST    (LOW_RST)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .wrAddr     (wrAddr),
    .wrData     (wrData),
    .marginSel  (marginSel),
    .strobe     (strobe),
    .trimCode   (trimCode),
    .targetCode (targetCode)
  );

endmodule

// File: tb/trim_loop_bench.sv
`timescale 1ns/1ps
module trim_loop_bench;

  logic       clk = 1'b0;
  logic       rstN;
  logic       compAbove;
  logic       tickEn;
  logic       wrEn;
  logic [1:0] wrAddr;
  logic [9:0] wrData;
  logic [1:0] marginSel;
  logic [9:0] trimCode;
  logic [9:0] targetCode;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  trim_loop u_trim_loop (
    .clk        (clk),
    .rstN       (rstN),
    .compAbove  (compAbove),
    .tickEn     (tickEn),
    .wrEn       (wrEn),
    .wrAddr     (wrAddr),
    .wrData     (wrData),
    .marginSel  (marginSel),
    .trimCode   (trimCode),
    .targetCode (targetCode)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wrReg(input logic [1:0] a, input int d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = 10'(d);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitChange(input int maxc, output int n, output int delta);
    logic [9:0] prev;
    prev = trimCode;
    n = 0;
    delta = 0;
    while (n < maxc) begin
      @(negedge clk);
      n++;
      if (trimCode != prev) begin
        delta = int'(trimCode) - int'(prev);
        return;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog (all requirements) actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int n, dl, val, exp, stepCount;
    logic [9:0] prevT;
    rstN = 1'b0; compAbove = 1'b0; tickEn = 1'b0; wrEn = 1'b0;
    wrAddr = '0; wrData = '0; marginSel = 2'd0;
    cycles(3);
    rstN = 1'b1;
    cycles(2);

    // R1 reset state
    check(trimCode == 10'd512, "R1 reset trim", int'(trimCode), 512);
    check(targetCode == 10'd600, "R1 reset target", int'(targetCode), 600);

    // R1 reset divisor 3: spacing of 4 cycles
    tickEn = 1'b1;
    waitChange(50, n, dl);
    waitChange(50, n, dl);
    check(n == 4, "R1 reset divisor spacing", n, 4);
    tickEn = 1'b0;
    cycles(3);

    // R5 no tick enable: frozen
    prevT = trimCode;
    cycles(100);
    check(trimCode == prevT, "R5 frozen trim", int'(trimCode), int'(prevT));

    // R6 / R2 divisor sweep, comparator low -> up steps (R3)
    for (int d = 0; d < 8; d++) begin
      tickEn = 1'b0;
      wrReg(2'd3, d);
      tickEn = 1'b1;
      waitChange(100, n, dl);
      for (int k = 0; k < 3; k++) begin
        waitChange(100, n, dl);
        check(n == d + 1, "R6 update spacing", n, d + 1);
        check(dl == 1, "R2 R3 unit up step", dl, 1);
      end
    end

    // R3 comparator high -> down steps
    tickEn = 1'b0;
    wrReg(2'd3, 3);
    compAbove = 1'b1;
    cycles(5);
    tickEn = 1'b1;
    waitChange(100, n, dl);
    for (int k = 0; k < 4; k++) begin
      waitChange(100, n, dl);
      check(dl == -1, "R3 R2 unit down step", dl, -1);
      check(n == 4, "R6 spacing divisor 3", n, 4);
    end

    // R4 saturation at both rails
    wrReg(2'd3, 0);
    compAbove = 1'b0;
    cycles(1100);
    check(trimCode == 10'd1023, "R4 top saturation", int'(trimCode), 1023);
    cycles(50);
    check(trimCode == 10'd1023, "R4 top no wrap", int'(trimCode), 1023);
    compAbove = 1'b1;
    cycles(1100);
    check(trimCode == 10'd0, "R4 bottom saturation", int'(trimCode), 0);
    cycles(50);
    check(trimCode == 10'd0, "R4 bottom no wrap", int'(trimCode), 0);

    // R7 / R8 select decode and tick-aligned switch
    tickEn = 1'b0;
    wrReg(2'd1, 700);
    marginSel = 2'd1;
    cycles(20);
    check(targetCode == 10'd600, "R8 target held without update", int'(targetCode), 600);
    wrReg(2'd0, 620);
    cycles(5);
    check(targetCode == 10'd600, "R8 write held without update", int'(targetCode), 600);
    tickEn = 1'b1;
    cycles(5);
    check(targetCode == 10'd700, "R7 select high", int'(targetCode), 700);
    marginSel = 2'd2;
    cycles(5);
    check(targetCode == 10'd540, "R7 select low", int'(targetCode), 540);
    marginSel = 2'd3;
    cycles(5);
    check(targetCode == 10'd620, "R7 select 3 is nominal", int'(targetCode), 620);
    marginSel = 2'd0;
    cycles(5);
    check(targetCode == 10'd620, "R7 select nominal", int'(targetCode), 620);

    // R9 floor clamp sweep on the low setpoint
    marginSel = 2'd2;
    for (int v = 0; v < 128; v++) begin
      wrReg(2'd2, v);
      cycles(4);
      exp = (v < 96) ? 96 : v;
      check(targetCode == 10'(exp), "R9 floor clamp", int'(targetCode), exp);
    end
    wrReg(2'd0, 10);
    marginSel = 2'd0;
    cycles(4);
    check(targetCode == 10'd96, "R9 nominal clamp", int'(targetCode), 96);

    // R10 closed loop limit cycle against threshold 300
    tickEn = 1'b0;
    wrReg(2'd3, 3);
    tickEn = 1'b1;
    stepCount = 0;
    val = 300;
    for (int i = 0; i < 1600; i++) begin
      @(negedge clk);
      if (i >= 1400) begin
        if (trimCode != prevT) stepCount++;
        check((trimCode == 10'(val)) || (trimCode == 10'(val + 1)), "R10 limit cycle band", int'(trimCode), val);
      end
      prevT = trimCode;
      compAbove = (int'(trimCode) > val);
    end
    check(stepCount >= 40, "R10 limit cycle keeps stepping", stepCount, 40);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule